// File: doc/BRIEF.md
# Variable-Step BCD Fare Accumulator

This block holds a taxi fare as four packed BCD digits, from 000.0 to 999.9, with a resolution of one tenth of a currency unit. A high level on the clear input loads a starting price. The price comes from a four-entry table that a two-bit select input indexes. After that, every clock cycle in which the charge strobe is high adds one step to the fare. The distance logic upstream raises this strobe once for every 500 m travelled.

The step depends on the current fare. While the fare is at or below a preset limit, the step is the base step. Once the fare is strictly above the limit, and the surcharge enable input is high, the step is the larger surcharge step. The sum is formed digit by digit within one cycle. Each digit is corrected by adding six whenever its raw sum exceeds nine or carries out of four bits. If the sum would pass 999.9, the fare saturates at 999.9.

Top module: `fare_accum`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the fare becomes 000.0 (all four digits 0) after that edge.
- R2: A clock edge with clear high loads the starting price given by the select input. Select 0 gives 5.0, 1 gives 6.0, 2 gives 7.0 and 3 gives 8.0. The fare output packs the hundreds digit in bits 15:12, the tens digit in 11:8, the units digit in 7:4 and the tenths digit in 3:0.
- R3: When clear and charge are both high at an edge, clear wins: the starting price is loaded and no step is added.
- R4: A charge edge adds 0.6 when the fare before the edge is at most 15.0, or when surcharge enable is low.
- R5: A charge edge adds 0.9 when surcharge enable is high and the fare before the edge is strictly greater than 15.0. A fare of exactly 15.0 still takes 0.6.
- R6: Every digit of the fare always stays within 0 to 9. This includes digit sums of 10 to 15 and digit sums of 16 or more, which carry out of four bits.
- R7: An edge with neither clear nor charge high leaves the fare unchanged, whatever the select and surcharge inputs do.
- R8: A charge whose sum would exceed 999.9 leaves the fare at 999.9, and further charges keep it there.
- R9: A carry from one digit ripples into every higher digit within the same edge. For example, 099.8 + 0.6 gives 100.4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Start/clear: loads the starting price |
| charge | input | 1 | One-cycle strobe for each 500 m charge |
| start_sel | input | 2 | Starting-price select |
| surch_en | input | 1 | Enables the surcharge step above the limit |
| fare | output | 16 | Four packed BCD digits, tenths in bits 3:0 |

## Verification
Every result of this block appears one clock edge after the stimulus that causes it, because the fare register is the only stage between the inputs and the output. The bench changes its inputs on the falling edge. It then waits for the next falling edge, half a period after the active rising edge, before it compares the fare with a model that works in integer tenths of a unit. This keeps each check on the cycle whose edge consumed the stimulus, both for single operations and for long runs of charges. Those runs cover the limit boundary, the digit sums that carry out of four bits, the ripple carries across several digits and saturation.

// File: rtl/fare_pkg.sv
package fare_pkg;
  localparam int DIG_W = 4;
  localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;
  localparam logic [DIG_W-1:0] DIG_ADJ = 4'd6;
  typedef logic [DIG_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import fare_pkg::*;
(
  input  bcd_digit_t a,
  input  bcd_digit_t b,
  input  logic       cin,
  output bcd_digit_t sum,
  output logic       cout
);
  logic [DIG_W:0] raw;
  logic           adjust;

  always_comb begin
    raw    = {1'b0, a} + {1'b0, b} + {{DIG_W{1'b0}}, cin};
    // half-carry out of the nibble, or a nibble value above nine
    adjust = raw[DIG_W] || (raw[DIG_W-1:0] > DIG_MAX);
    sum    = adjust ? (raw[DIG_W-1:0] + DIG_ADJ) : raw[DIG_W-1:0];
    cout   = adjust;
  end
endmodule

// File: rtl/bcd_add_chain.sv
module bcd_add_chain
  import fare_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int W = NDIG * DIG_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  logic [NDIG:0] carry;

  assign carry[0] = 1'b0;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    bcd_digit_add u_add (
      .a   (a[d*DIG_W +: DIG_W]),
      .b   (b[d*DIG_W +: DIG_W]),
      .cin (carry[d]),
      .sum (sum[d*DIG_W +: DIG_W]),
      .cout(carry[d+1])
    );
  end

  assign carry_out = carry[NDIG];
endmodule

// File: rtl/fare_start_rom.sv
module fare_start_rom
  import fare_pkg::*;
#(
  parameter int NDIG  = 4,
  parameter int SEL_W = 2,
  localparam int W       = NDIG * DIG_W,
  localparam int ENTRIES = 1 << SEL_W,
  parameter logic [ENTRIES*W-1:0] TABLE = {16'h0080, 16'h0070, 16'h0060, 16'h0050}
) (
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     price
);
  logic [W-1:0] entry [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign entry[i] = TABLE[i*W +: W];
  end

  assign price = entry[sel];
endmodule

// File: rtl/fare_step_sel.sv
module fare_step_sel
  import fare_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int W = NDIG * DIG_W,
  parameter logic [W-1:0] LIMIT      = 16'h0150,
  parameter logic [W-1:0] BASE_STEP  = 16'h0006,
  parameter logic [W-1:0] SURCH_STEP = 16'h0009
) (
  input  logic [W-1:0] fare_now,
  input  logic         surch_en,
  output logic [W-1:0] step
);
  logic above;

  // packed BCD keeps numeric order, so a plain compare suffices
  assign above = fare_now > LIMIT;
  assign step  = (surch_en && above) ? SURCH_STEP : BASE_STEP;
endmodule

// File: rtl/fare_accum.sv
module fare_accum
  import fare_pkg::*;
#(
  parameter int NDIG  = 4,
  parameter int SEL_W = 2,
  localparam int W       = NDIG * DIG_W,
  localparam int ENTRIES = 1 << SEL_W,
  parameter logic [ENTRIES*W-1:0] START_TABLE = {16'h0080, 16'h0070, 16'h0060, 16'h0050},
  parameter logic [W-1:0] LIMIT      = 16'h0150,
  parameter logic [W-1:0] BASE_STEP  = 16'h0006,
  parameter logic [W-1:0] SURCH_STEP = 16'h0009
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             charge,
  input  logic [SEL_W-1:0] start_sel,
  input  logic             surch_en,
  output logic [W-1:0]     fare
);
  localparam logic [W-1:0] SAT_VAL = {NDIG{DIG_MAX}};

  logic [W-1:0] start_price;
  logic [W-1:0] step;
  logic [W-1:0] next_sum;
  logic         ovf;

  fare_start_rom #(.NDIG(NDIG), .SEL_W(SEL_W), .TABLE(START_TABLE)) u_rom (
    .sel  (start_sel),
    .price(start_price)
  );

  fare_step_sel #(.NDIG(NDIG), .LIMIT(LIMIT), .BASE_STEP(BASE_STEP),
                  .SURCH_STEP(SURCH_STEP)) u_step (
    .fare_now(fare),
    .surch_en(surch_en),
    .step    (step)
  );

  bcd_add_chain #(.NDIG(NDIG)) u_add (
    .a        (fare),
    .b        (step),
    .sum      (next_sum),
    .carry_out(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fare <= '0;
    end else if (clr) begin
      fare <= start_price;
    end else if (charge) begin
      fare <= ovf ? SAT_VAL : next_sum;
    end
  end
endmodule

// File: rtl/fare_accum_chk.sv
module fare_accum_chk
  import fare_pkg::*;
#(
  parameter int NDIG  = 4,
  parameter int SEL_W = 2,
  localparam int W       = NDIG * DIG_W,
  localparam int ENTRIES = 1 << SEL_W,
  parameter logic [ENTRIES*W-1:0] START_TABLE = {16'h0080, 16'h0070, 16'h0060, 16'h0050}
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             charge,
  input logic [SEL_W-1:0] start_sel,
  input logic [W-1:0]     fare
);
  localparam logic [W-1:0] SAT_VAL = {NDIG{DIG_MAX}};

  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int d = 0; d < NDIG; d++) begin
      if (fare[d*DIG_W +: DIG_W] > DIG_MAX) digits_ok = 1'b0;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> fare == '0); // R1
  AST_CLR_LOADS: assert property (@(posedge clk) disable iff (rst)
    clr |=> fare == START_TABLE[$past(start_sel)*W +: W]); // R2
  AST_DIGITS_BCD: assert property (@(posedge clk) disable iff (rst) digits_ok); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr && !charge) |=> $stable(fare)); // R7
  AST_CHARGE_GROWS: assert property (@(posedge clk) disable iff (rst)
    (charge && !clr && fare != SAT_VAL) |=> fare > $past(fare)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (charge && !clr && fare == SAT_VAL) |=> fare == SAT_VAL); // R8
endmodule

bind fare_accum fare_accum_chk #(.NDIG(NDIG), .SEL_W(SEL_W), .START_TABLE(START_TABLE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .charge   (charge),
  .start_sel(start_sel),
  .fare     (fare)
);

// File: tb/tb_fare_accum.sv
`timescale 1ns/1ps
module tb_fare_accum;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        charge = 1'b0;
  logic [1:0]  start_sel = 2'd0;
  logic        surch_en = 1'b0;
  logic [15:0] fare;

  int checks = 0;
  int failures = 0;
  int exp_t = 0;   // expected fare in tenths
  bit done = 1'b0;

  always #10 clk = ~clk;

  fare_accum dut (
    .clk(clk), .rst(rst), .clr(clr), .charge(charge),
    .start_sel(start_sel), .surch_en(surch_en), .fare(fare)
  );

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (fare !== exp) begin
      failures++;
      $display("FAIL %s fare=%h expected=%h", tag, fare, exp);
    end
  endtask

  // drive at falling edge, let one rising edge pass, update the model, check
  task automatic step_cycle(input bit c, input bit ch, input logic [1:0] s,
                            input bit se, input string tag);
    int st;
    clr = c; charge = ch; start_sel = s; surch_en = se;
    @(negedge clk);
    if (c) exp_t = 50 + 10 * int'(s);
    else if (ch) begin
      st = (se && exp_t > 150) ? 9 : 6;
      exp_t = (exp_t + st > 9999) ? 9999 : exp_t + st;
    end
    check(tag, to_bcd(exp_t));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    exp_t = 0;
    check("R1 reset", 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_start_table;
    for (int s = 0; s < 4; s++) step_cycle(1, 0, 2'(s), 0, "R2 start price");
    check("R2 select 3 loads 8.0", 16'h0080);
  endtask

  task automatic t_clr_priority;
    step_cycle(1, 1, 2'd1, 1, "R3 clear beats charge");
    check("R3 loaded 6.0 only", 16'h0060);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 6; i++) step_cycle(0, 0, 2'(i), i[0], "R7 idle hold");
    check("R7 still 6.0", 16'h0060);
  endtask

  task automatic t_surcharge;
    step_cycle(1, 0, 2'd1, 1, "R2 load 6.0");
    for (int i = 0; i < 15; i++) step_cycle(0, 1, 2'd0, 1, "R4 base step");
    check("R5 exactly 15.0 reached", 16'h0150);
    step_cycle(0, 1, 2'd0, 1, "R5 at limit keeps 0.6");
    check("R5 15.6", 16'h0156);
    step_cycle(0, 1, 2'd0, 1, "R5 surcharge step");
    check("R5 R6 16.5 half-carry", 16'h0165);
    for (int i = 0; i < 7; i++) step_cycle(0, 1, 2'd0, 1, "R5 R6 surcharge run");
    check("R6 22.8 from 9+9", 16'h0228);
  endtask

  task automatic t_surch_off;
    step_cycle(0, 1, 2'd0, 0, "R4 surcharge disabled");
    check("R4 23.4", 16'h0234);
  endtask

  task automatic t_ripple_sat;
    step_cycle(1, 0, 2'd0, 0, "R2 load 5.0");
    for (int i = 0; i < 1700; i++) step_cycle(0, 1, 2'd0, 0, "R4 R9 R8 long run");
    check("R8 saturated 999.9", 16'h9999);
    step_cycle(0, 1, 2'd3, 1, "R8 stays saturated");
    step_cycle(1, 0, 2'd0, 0, "R2 reload 5.0");
    for (int i = 0; i < 158; i++) step_cycle(0, 1, 2'd0, 0, "R9 run to 99.8");
    check("R9 99.8 reached", 16'h0998);
    step_cycle(0, 1, 2'd0, 0, "R9 ripple");
    check("R9 100.4 ripple", 16'h1004);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_start_table();
    t_clr_priority();
    t_hold();
    t_surcharge();
    t_surch_off();
    t_ripple_sat();
    t_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule